// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Priority Threshold

This block gathers up to 64 level-sensitive interrupt request lines and presents one interrupt output to a processor. Each line has its own 6-bit priority and its own enable bit. A priority value of 0 is the most urgent, and larger values are less urgent. A line counts as pending when its request input is high and its enable bit is set. Among the pending lines, the controller picks the one with the smallest priority value. When several lines share that value, the lowest line number wins.

A programmable 8-bit threshold masks every pending line whose priority value is not strictly below it. A handler can raise the bar to the priority it is servicing, so that only more urgent sources interrupt it. This shortens the latency of urgent sources.

When the output rises, the winning line number and its priority are latched into two read-only registers. They hold, together with the output, until software writes the acknowledge (new-agreement) register. Arbitration then runs again on the following cycle. All registers are reached through a synchronous byte-wide read/write port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the interrupt output is low, the active-number register reads 0x80, the active-priority register reads 0x00, the threshold reads 0xFF, and all priority and enable registers read 0x00.
- R2: Register map with 8-bit data. The priority register of line n sits at address n and holds the priority in bits [7:2]; bits [1:0] always read 0. Enable bits sit at address 0x40 + n/8, bit n%8. The threshold is at 0x48, the active number at 0x49, the active priority at 0x4A and acknowledge at 0x4B. Read data appears on the cycle after the address is presented. Writes to 0x49 and 0x4A have no effect.
- R3: A line takes part in arbitration only while its request input is high and its enable bit is 1. A disabled line or a low line never raises the output.
- R4: Among the unmasked pending lines, the one with the smallest priority value wins. A tie goes to the lowest line number.
- R5: A pending line is unmasked only if its priority value is strictly less than the threshold. A priority equal to the threshold is masked, and a threshold of 0xFF masks nothing.
- R6: While no interrupt is held and an unmasked pending line exists, the output rises on the next clock edge. At that edge the active number latches the line number in bits [5:0] with bit 7 clear, and the active priority latches the priority in bits [5:0].
- R7: While the output is high, the output, the active number and the active priority do not change, whatever happens on the request, priority, enable or threshold inputs, until an acknowledge write.
- R8: An acknowledge write drives the output low on the following edge. Arbitration runs again on the edge after that.
- R9: While no interrupt is held and no unmasked pending line exists, the output is low, the active number reads 0x80 and the active priority reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | 64 | Level-sensitive request lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after the address |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
A corrupted latch shows up at once in the active-number or active-priority read, or as an output that fails to drop on the edge after an acknowledge. A fault in the arbiter's comparison, such as a wrong tie order or an inclusive instead of strict threshold test, shows up one edge after the output rises, as the wrong line or priority in the latched registers. A broken enable, priority or threshold register shows up either at the port one cycle after its address is presented or in the next arbitration result. The bench therefore reads back every latched value right after each rise and each acknowledge.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [2:0] {
    SEL_LEVEL,
    SEL_ENABLE,
    SEL_THRESH,
    SEL_ACTNUM,
    SEL_ACTPRI,
    SEL_AGREE,
    SEL_NONE
  } pic_sel_e;

  // Map an address onto a register region: per-line levels first, then the
  // enable bytes, then four single registers.
  function automatic pic_sel_e pic_decode(input int unsigned a,
                                          input int unsigned n_lines,
                                          input int unsigned en_bytes);
    pic_sel_e s;
    if (a < n_lines)                      s = SEL_LEVEL;
    else if (a < n_lines + en_bytes)      s = SEL_ENABLE;
    else if (a == n_lines + en_bytes)     s = SEL_THRESH;
    else if (a == n_lines + en_bytes + 1) s = SEL_ACTNUM;
    else if (a == n_lines + en_bytes + 2) s = SEL_ACTPRI;
    else if (a == n_lines + en_bytes + 3) s = SEL_AGREE;
    else                                  s = SEL_NONE;
    return s;
  endfunction

endpackage

// File: rtl/pic_regfile.sv
module pic_regfile
  import pic_pkg::*;
#(
  parameter int unsigned N_LINES = 64,
  parameter int unsigned PRIO_W  = 6,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [PRIO_W-1:0]  prio_o [N_LINES],
  output logic [N_LINES-1:0] en_o,
  output logic [DATA_W-1:0]  thresh_o,
  output logic               agree_o
);
  localparam int unsigned IDW  = $clog2(N_LINES);
  localparam int unsigned EB   = N_LINES / DATA_W;
  localparam int unsigned EBW  = (EB > 1) ? $clog2(EB) : 1;

  pic_sel_e            sel;
  logic [ADDR_W-1:0]   en_off;
  logic [EBW-1:0]      en_idx;
  logic [IDW-1:0]      lvl_idx;

  assign sel     = pic_decode(32'(addr_i), N_LINES, EB);
  assign en_off  = addr_i - ADDR_W'(N_LINES);
  assign en_idx  = en_off[EBW-1:0];
  assign lvl_idx = addr_i[IDW-1:0];
  assign agree_o = wr_en_i && (sel == SEL_AGREE);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_LINES; i++) prio_o[i] <= '0;
      en_o     <= '0;
      thresh_o <= '1;
    end else if (wr_en_i) begin
      case (sel)
        SEL_LEVEL:  prio_o[lvl_idx] <= wdata_i[PRIO_W+1:2];
        SEL_ENABLE: en_o[en_idx*DATA_W +: DATA_W] <= wdata_i;
        SEL_THRESH: thresh_o <= wdata_i;
        default: ;
      endcase
    end
  end

  // R2: a write to a level address changes that line's priority on the next edge
  assert_level_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && sel == SEL_LEVEL) |=> (prio_o[$past(lvl_idx)] == $past(wdata_i[PRIO_W+1:2])));

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int unsigned N_LINES = 64,
  parameter int unsigned PRIO_W  = 6,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned IDW    = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] en_i,
  input  logic [PRIO_W-1:0]  prio_i [N_LINES],
  input  logic [DATA_W-1:0]  thresh_i,
  output logic               win_valid_o,
  output logic [IDW-1:0]     win_id_o,
  output logic [PRIO_W-1:0]  win_prio_o
);
  // Linear scan from line 0 upward. Only a strictly smaller value replaces the
  // current best, so the lowest line number keeps a tie.
  always_comb begin
    win_valid_o = 1'b0;
    win_id_o    = '0;
    win_prio_o  = '1;
    for (int i = 0; i < N_LINES; i++) begin
      if (req_i[i] && en_i[i] && (DATA_W'(prio_i[i]) < thresh_i) &&
          (!win_valid_o || (prio_i[i] < win_prio_o))) begin
        win_valid_o = 1'b1;
        win_id_o    = IDW'(i);
        win_prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/pic_capture.sv
module pic_capture #(
  parameter int unsigned IDW    = 6,
  parameter int unsigned PRIO_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              agree_i,
  input  logic              win_valid_i,
  input  logic [IDW-1:0]    win_id_i,
  input  logic [PRIO_W-1:0] win_prio_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] act_num_o,
  output logic [PRIO_W-1:0] act_prio_o
);
  localparam logic [DATA_W-1:0] SPUR = {1'b1, {(DATA_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o      <= 1'b0;
      act_num_o  <= SPUR;
      act_prio_o <= '0;
    end else if (agree_i) begin
      irq_o      <= 1'b0;
      act_num_o  <= SPUR;
      act_prio_o <= '0;
    end else if (!irq_o) begin
      if (win_valid_i) begin
        irq_o      <= 1'b1;
        act_num_o  <= DATA_W'(win_id_i);
        act_prio_o <= win_prio_i;
      end else begin
        act_num_o  <= SPUR;
        act_prio_o <= '0;
      end
    end
  end

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !agree_i) |=> (irq_o && $stable(act_num_o) && $stable(act_prio_o)));

  assert_agree_drop_R8: assert property (@(posedge clk) disable iff (rst)
    agree_i |=> !irq_o);

  assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
    (!irq_o && !agree_i && win_valid_i) |=>
      (irq_o && act_num_o == DATA_W'($past(win_id_i)) && act_prio_o == $past(win_prio_i)));

  assert_spurious_R9: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> (act_num_o == SPUR && act_prio_o == '0));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned N_LINES = 64,
  parameter int unsigned PRIO_W  = 6,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_src_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  localparam int unsigned IDW = $clog2(N_LINES);
  localparam int unsigned EB  = N_LINES / DATA_W;
  localparam int unsigned EBW = (EB > 1) ? $clog2(EB) : 1;

  logic [PRIO_W-1:0]  prio [N_LINES];
  logic [N_LINES-1:0] en_vec;
  logic [DATA_W-1:0]  thresh;
  logic               agree;
  logic               win_valid;
  logic [IDW-1:0]     win_id;
  logic [PRIO_W-1:0]  win_prio;
  logic [DATA_W-1:0]  act_num;
  logic [PRIO_W-1:0]  act_prio;

  pic_regfile #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .prio_o(prio), .en_o(en_vec), .thresh_o(thresh), .agree_o(agree)
  );

  pic_arbiter #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_arb (
    .req_i(irq_src_i), .en_i(en_vec), .prio_i(prio), .thresh_i(thresh),
    .win_valid_o(win_valid), .win_id_o(win_id), .win_prio_o(win_prio)
  );

  pic_capture #(.IDW(IDW), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .agree_i(agree), .win_valid_i(win_valid),
    .win_id_i(win_id), .win_prio_i(win_prio),
    .irq_o(irq_o), .act_num_o(act_num), .act_prio_o(act_prio)
  );

  // Registered read port
  pic_sel_e          rsel;
  logic [ADDR_W-1:0] en_off;
  logic [EBW-1:0]    en_idx;

  assign rsel   = pic_decode(32'(addr_i), N_LINES, EB);
  assign en_off = addr_i - ADDR_W'(N_LINES);
  assign en_idx = en_off[EBW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      case (rsel)
        SEL_LEVEL:  rdata_o <= DATA_W'({prio[addr_i[IDW-1:0]], 2'b00});
        SEL_ENABLE: rdata_o <= en_vec[en_idx*DATA_W +: DATA_W];
        SEL_THRESH: rdata_o <= thresh;
        SEL_ACTNUM: rdata_o <= act_num;
        SEL_ACTPRI: rdata_o <= DATA_W'(act_prio);
        default:    rdata_o <= '0;
      endcase
    end
  end

  assert_below_thresh_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (DATA_W'(act_prio) < $past(thresh)));

  assert_pending_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(irq_src_i & en_vec) != '0));

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string what; } exp_t;
  exp_t sb[$];
  logic rd_req = 1'b0;
  logic rd_req_d = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst(rst), .irq_src_i(src), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // Monitor: read data is ready one edge after the request.
  always @(posedge clk) rd_req_d <= rd_req;
  always @(negedge clk) begin
    if (rd_req_d && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      compared++;
      if (rdata !== e.exp) begin
        mismatched++;
        $display("FAIL %s: rdata=0x%02h expected 0x%02h", e.what, rdata, e.exp);
      end
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [7:0] e, input string what);
    @(negedge clk); addr = a; sb.push_back('{e, what}); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic irq_now(input logic e, input string what);
    compared++;
    if (irq !== e) begin
      mismatched++;
      $display("FAIL %s: irq=%0b expected %0b", what, irq, e);
    end
  endtask

  task automatic irq_step(input logic e, input string what);
    @(negedge clk);
    irq_now(e, what);
  endtask

  task automatic ack();
    wr_reg(8'h4B, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    irq_now(1'b0, "R1 irq after reset");
    rd_expect(8'h48, 8'hFF, "R1 threshold");
    rd_expect(8'h49, 8'h80, "R1 active number");
    rd_expect(8'h4A, 8'h00, "R1 active priority");
    rd_expect(8'h05, 8'h00, "R1 level reg");
    rd_expect(8'h40, 8'h00, "R1 enable reg");

    // R3: requests present but all lines disabled
    @(negedge clk); src[3] = 1'b1; src[41] = 1'b1; src[42] = 1'b1;
    wr_reg(8'd41, 8'hB0);
    wr_reg(8'd42, 8'hB0);
    wr_reg(8'd3, 8'hC8);
    irq_step(1'b0, "R3 disabled lines silent");
    rd_expect(8'h49, 8'h80, "R3 no active line");

    // R4/R6: tie at priority 44 goes to line 41
    wr_reg(8'h45, 8'h06);
    irq_step(1'b1, "R6 irq rises");
    rd_expect(8'h49, 8'h29, "R4 tie to lowest line");
    rd_expect(8'h4A, 8'h2C, "R6 active priority");

    // R7: hold while priorities and enables change
    wr_reg(8'h40, 8'h08);
    wr_reg(8'd42, 8'h04);
    irq_now(1'b1, "R7 irq held");
    rd_expect(8'h49, 8'h29, "R7 number held");
    rd_expect(8'h4A, 8'h2C, "R7 priority held");

    // R8: acknowledge drops, then rerun picks line 42 at priority 1
    ack();
    irq_now(1'b0, "R8 drop after ack");
    irq_step(1'b1, "R8 rerun");
    rd_expect(8'h49, 8'h2A, "R4 smaller value wins");
    rd_expect(8'h4A, 8'h01, "R8 new priority");

    // R5: threshold equal to priority masks it
    wr_reg(8'h48, 8'h01);
    ack();
    irq_now(1'b0, "R8 drop");
    irq_step(1'b0, "R5 equal threshold masked");
    rd_expect(8'h49, 8'h80, "R9 spurious number");
    rd_expect(8'h4A, 8'h00, "R9 spurious priority");
    wr_reg(8'h48, 8'h02);
    irq_step(1'b1, "R5 below threshold passes");
    rd_expect(8'h49, 8'h2A, "R5 line 42");

    // R5: boundary at 44 / 45
    wr_reg(8'd42, 8'hB0);
    wr_reg(8'h48, 8'h2C);
    ack();
    irq_step(1'b0, "R5 equal 44 masked");
    wr_reg(8'h48, 8'h2D);
    irq_step(1'b1, "R5 44 below 45");
    rd_expect(8'h49, 8'h29, "R4 tie again line 41");

    // R3/R7: dropping the held source keeps the hold; after ack, 42 wins
    @(negedge clk); src[41] = 1'b0;
    irq_step(1'b1, "R7 held after source drop");
    rd_expect(8'h49, 8'h29, "R7 number held after drop");
    ack();
    irq_step(1'b1, "R3 rerun without line 41");
    rd_expect(8'h49, 8'h2A, "R3 low line not pending");
    rd_expect(8'h4A, 8'h2C, "R3 priority 44");

    // R5: threshold 0xFF passes all
    wr_reg(8'h48, 8'hFF);
    wr_reg(8'd3, 8'h00);
    ack();
    irq_step(1'b1, "R5 0xFF no masking");
    rd_expect(8'h49, 8'h03, "R5 line 3 wins");
    rd_expect(8'h4A, 8'h00, "R5 priority 0");

    // R2: register map details
    rd_expect(8'd41, 8'hB0, "R2 level readback");
    wr_reg(8'd41, 8'hB3);
    rd_expect(8'd41, 8'hB0, "R2 low bits read 0");
    rd_expect(8'h45, 8'h06, "R2 enable byte");
    rd_expect(8'h40, 8'h08, "R2 enable byte 0");
    wr_reg(8'h49, 8'h11);
    wr_reg(8'h4A, 8'h22);
    rd_expect(8'h49, 8'h03, "R2 active number read-only");
    rd_expect(8'h4A, 8'h00, "R2 active priority read-only");

    // R9: nothing pending
    @(negedge clk); src = '0;
    ack();
    irq_step(1'b0, "R9 no line pending");
    rd_expect(8'h49, 8'h80, "R9 spurious flag");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule